// File: doc/BRIEF.md
# FIFO threshold interrupt controller

This block holds the interrupt and status side of a serial controller that owns one transmit FIFO and one receive FIFO. It follows the push and pop strobes of both FIFOs to keep their fill levels, and it compares those levels against programmable thresholds. Two threshold flags come out of that comparison: "transmit nearly empty" and "receive filled". It also catches the three FIFO misuse events (a push into a full transmit FIFO, a push into a full receive FIFO, a pop from an empty receive FIFO) and holds each one in a sticky error flag.

Software sees five things: the level counts, the threshold values as they read back, a raw status word that shows every cause before masking, a masked status word, and a single interrupt line. Each threshold register keeps only the low clog2(DEPTH) bits of what is written to it. Software can therefore find the FIFO depth by writing larger and larger values until the readback no longer matches. Each sticky flag is cleared by its own clear strobe, which a register read generates. The FIFO storage and the serial shifter are outside this block.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the state is as follows: both levels are 0, both thresholds read 0, the mask is 6'h3F, the sticky flags are clear and `irq` is 0. As a result `raw_stat` reads 6'h01.
- R2: Each level register goes up by one for an accepted push and down by one for an accepted pop. When an accepted push and an accepted pop arrive in the same cycle, the level does not change. The new value is visible in the cycle after the strobe.
- R3: A transmit push while `tx_level` equals DEPTH is dropped and the level stays the same. In the next cycle raw status bit 1 (transmit overflow) becomes 1, and it stays 1 until it is cleared.
- R4: A receive push at level DEPTH is dropped and sets sticky bit 3 (receive overflow). A receive pop at level 0 leaves the level at 0 and sets sticky bit 2 (receive underflow).
- R5: `clr_txo`, `clr_rxu` and `clr_rxo` clear bits 1, 2 and 3 respectively in the next cycle. If the matching error event occurs in the same cycle as the clear, the flag stays set.
- R6: Raw status bit 0 (transmit empty) is 1 exactly when `tx_level` is less than or equal to the transmit threshold.
- R7: Raw status bit 4 (receive full) is 1 exactly when `rx_level` is strictly greater than the receive threshold. A threshold of N-1 therefore fires at N entries.
- R8: A threshold write stores the low clog2(DEPTH) bits of `thr_wdata`, and the readback is that value zero-extended to REG_W bits. For example, with DEPTH 16, writing 20 reads back 4 and writing 15 reads back 15.
- R9: `mask_stat` equals `raw_stat` AND the mask. A mask write takes effect in the next cycle. Bit 5 of both status words is always 0.
- R10: In every cycle, `irq` equals the OR of the bits of `mask_stat` from the previous cycle. With an all-zero mask, `irq` stays 0 while `raw_stat` still shows the causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_push | input | 1 | Write into the transmit FIFO |
| tx_pop | input | 1 | Serial engine takes a transmit entry |
| rx_push | input | 1 | Serial engine stores a receive entry |
| rx_pop | input | 1 | Read from the receive FIFO |
| tx_thr_we | input | 1 | Write the transmit threshold |
| rx_thr_we | input | 1 | Write the receive threshold |
| thr_wdata | input | REG_W | Threshold write data |
| mask_we | input | 1 | Write the interrupt mask |
| mask_wdata | input | 6 | Mask write data |
| clr_txo | input | 1 | Clear the transmit overflow flag |
| clr_rxu | input | 1 | Clear the receive underflow flag |
| clr_rxo | input | 1 | Clear the receive overflow flag |
| tx_level | output | LVL_W | Transmit FIFO entry count |
| rx_level | output | LVL_W | Receive FIFO entry count |
| tx_thr_q | output | REG_W | Transmit threshold readback |
| rx_thr_q | output | REG_W | Receive threshold readback |
| raw_stat | output | 6 | Causes before masking |
| mask_stat | output | 6 | Causes after masking |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Some properties are checked by assertions in every cycle. Levels never go above DEPTH and never move by more than one step. A push at a full level leaves the level unchanged. A stored threshold always matches the truncated write data. Every overflow event is followed by its sticky flag, and a clear with no competing event drops that flag. An all-zero masked word is followed by a low `irq`.

Other behaviour is shown only by the bench scenarios. These cover the exact threshold boundaries for both comparison senses and the depth probe through threshold readback. They also cover a clear and an error event arriving in the same cycle, the one-cycle lag of `irq` after a mask change, and long random mixes of push and pop traffic that are compared against the reference model in every cycle.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int STAT_W = 6;
  localparam int ST_TXE = 0;
  localparam int ST_TXO = 1;
  localparam int ST_RXU = 2;
  localparam int ST_RXO = 3;
  localparam int ST_RXF = 4;
endpackage

// File: rtl/fifo_lvl_track.sv
module fifo_lvl_track #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             push_drop,
  output logic             pop_empty
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic push_ok, pop_ok;

  assign push_ok   = push && (level != FULL);
  assign pop_ok    = pop && (level != '0);
  assign push_drop = push && (level == FULL);
  assign pop_empty = pop && (level == '0);

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else if (push_ok && !pop_ok) level <= level + 1'b1;
    else if (pop_ok && !push_ok) level <= level - 1'b1;
  end

  // R2
  lvl_range_chk: assert property (@(posedge clk) disable iff (rst) level <= FULL);
  // R2
  lvl_up_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && level != FULL) |=> level == $past(level) + 1'b1);
  // R3
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && level == FULL) |=> level == FULL);
endmodule

// File: rtl/fifo_thr_reg.sv
module fifo_thr_reg #(
  parameter int DEPTH = 16,
  parameter int REG_W = 8,
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [THR_W-1:0] thr
);
  always_ff @(posedge clk) begin
    if (rst) thr <= '0;
    else if (we) thr <= wdata[THR_W-1:0];
  end

  // R8
  thr_wr_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> thr == $past(wdata[THR_W-1:0]));
  // R8
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(thr));
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int REG_W = 8,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              tx_thr_we,
  input  logic              rx_thr_we,
  input  logic [REG_W-1:0]  thr_wdata,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              clr_txo,
  input  logic              clr_rxu,
  input  logic              clr_rxo,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  output logic [REG_W-1:0]  tx_thr_q,
  output logic [REG_W-1:0]  rx_thr_q,
  output logic [STAT_W-1:0] raw_stat,
  output logic [STAT_W-1:0] mask_stat,
  output logic              irq
);
  logic             tx_drop, tx_under_unused, rx_drop, rx_under;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [STAT_W-1:0] mask_q;
  logic             txo_q, rxu_q, rxo_q;

  fifo_lvl_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_lvl (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
    .level(tx_level), .push_drop(tx_drop), .pop_empty(tx_under_unused));

  fifo_lvl_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_lvl (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
    .level(rx_level), .push_drop(rx_drop), .pop_empty(rx_under));

  fifo_thr_reg #(.DEPTH(DEPTH), .REG_W(REG_W), .THR_W(THR_W)) u_tx_thr (
    .clk(clk), .rst(rst), .we(tx_thr_we), .wdata(thr_wdata), .thr(tx_thr));

  fifo_thr_reg #(.DEPTH(DEPTH), .REG_W(REG_W), .THR_W(THR_W)) u_rx_thr (
    .clk(clk), .rst(rst), .we(rx_thr_we), .wdata(thr_wdata), .thr(rx_thr));

  assign tx_thr_q = REG_W'(tx_thr);
  assign rx_thr_q = REG_W'(rx_thr);

  // Sticky error flags: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
      rxo_q <= 1'b0;
    end else begin
      txo_q <= tx_drop  | (txo_q & ~clr_txo);
      rxu_q <= rx_under | (rxu_q & ~clr_rxu);
      rxo_q <= rx_drop  | (rxo_q & ~clr_rxo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_comb begin
    raw_stat         = '0;
    raw_stat[ST_TXE] = tx_level <= LVL_W'(tx_thr);
    raw_stat[ST_TXO] = txo_q;
    raw_stat[ST_RXU] = rxu_q;
    raw_stat[ST_RXO] = rxo_q;
    raw_stat[ST_RXF] = rx_level > LVL_W'(rx_thr);
  end

  assign mask_stat = raw_stat & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= |mask_stat;
  end

  // R3
  txo_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_drop |=> raw_stat[ST_TXO]);
  // R4
  rxo_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> raw_stat[ST_RXO]);
  // R5
  txo_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_txo && !tx_drop) |=> !raw_stat[ST_TXO]);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_stat == '0) |=> !irq);
endmodule

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;
  localparam int D = 16;
  localparam int RW = 8;
  localparam int LW = $clog2(D + 1);

  logic clk = 0, rst = 1;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic tx_thr_we = 0, rx_thr_we = 0, mask_we = 0;
  logic [RW-1:0] thr_wdata = 0;
  logic [5:0] mask_wdata = 0;
  logic clr_txo = 0, clr_rxu = 0, clr_rxo = 0;
  logic [LW-1:0] tx_level, rx_level;
  logic [RW-1:0] tx_thr_q, rx_thr_q;
  logic [5:0] raw_stat, mask_stat;
  logic irq;

  int checks = 0, errors = 0;
  // reference model state
  int tl = 0, rl = 0, tt = 0, rt = 0;
  bit [5:0] mk = 6'h3F;
  bit txo = 0, rxu = 0, rxo = 0, mirq = 0;

  always #2 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(D), .REG_W(RW)) u_dut (.*);

  function automatic bit [5:0] m_raw();
    bit [5:0] r = '0;
    r[0] = tl <= tt; r[1] = txo; r[2] = rxu; r[3] = rxo; r[4] = rl > rt;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [5:0] r = m_raw();
    chk(tx_level == LW'(tl), "R2 tx_level", tx_level, tl);
    chk(rx_level == LW'(rl), "R2 rx_level", rx_level, rl);
    chk(raw_stat[0] == r[0], "R6 txe", raw_stat[0], r[0]);
    chk(raw_stat[1] == r[1], "R3 R5 txo", raw_stat[1], r[1]);
    chk(raw_stat[3:2] == r[3:2], "R4 R5 rx errors", raw_stat[3:2], r[3:2]);
    chk(raw_stat[5:4] == r[5:4], "R7 rxf", raw_stat[5:4], r[5:4]);
    chk(tx_thr_q == RW'(tt) && rx_thr_q == RW'(rt), "R8 thresholds", {tx_thr_q, rx_thr_q}, {RW'(tt), RW'(rt)});
    chk(mask_stat == (r & mk), "R9 masked", mask_stat, r & mk);
    chk(irq == mirq, "R10 irq", irq, mirq);
  endtask

  // At a negedge: compare, then apply the currently set inputs for one clock.
  task automatic step();
    bit [5:0] r;
    int tl_n, rl_n;
    compare();
    r = m_raw();
    tl_n = tl + ((tx_push && tl != D) ? 1 : 0) - ((tx_pop && tl != 0) ? 1 : 0);
    rl_n = rl + ((rx_push && rl != D) ? 1 : 0) - ((rx_pop && rl != 0) ? 1 : 0);
    txo = (tx_push && tl == D) || (txo && !clr_txo);
    rxu = (rx_pop && rl == 0) || (rxu && !clr_rxu);
    rxo = (rx_push && rl == D) || (rxo && !clr_rxo);
    mirq = |(r & mk);
    if (tx_thr_we) tt = thr_wdata % D;
    if (rx_thr_we) rt = thr_wdata % D;
    if (mask_we) mk = mask_wdata;
    tl = tl_n; rl = rl_n;
    @(negedge clk);
  endtask

  task automatic idle();
    {tx_push, tx_pop, rx_push, rx_pop, tx_thr_we, rx_thr_we, mask_we, clr_txo, clr_rxu, clr_rxo} = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
    chk(raw_stat == 6'h01 && mask_stat == 6'h01, "R1 status", raw_stat, 6'h01);
    chk(irq == 0 && tx_thr_q == 0 && rx_thr_q == 0, "R1 irq/thr", irq, 0);
    rst = 0;
    compare();
    // R8 depth probe
    idle(); tx_thr_we = 1; thr_wdata = 20; step(); idle();
    chk(tx_thr_q == 4, "R8 probe 20", tx_thr_q, 4);
    tx_thr_we = 1; thr_wdata = 15; step(); idle();
    chk(tx_thr_q == 15, "R8 probe 15", tx_thr_q, 15);
    // fill tx past full: overflow (R3)
    tx_thr_we = 1; thr_wdata = 3; step(); idle();
    for (int i = 0; i < D + 2; i++) begin tx_push = 1; step(); end
    idle(); step();
    chk(raw_stat[1] == 1 && tx_level == LW'(D), "R3 overflow sticky", raw_stat, 2);
    // clear together with new overflow: stays set (R5)
    tx_push = 1; clr_txo = 1; step(); idle(); step();
    chk(raw_stat[1] == 1, "R5 event beats clear", raw_stat[1], 1);
    clr_txo = 1; step(); idle(); step();
    chk(raw_stat[1] == 0, "R5 clear", raw_stat[1], 0);
    // receive threshold boundary (R7): thr 2 fires at 3 entries
    rx_thr_we = 1; thr_wdata = 2; step(); idle();
    rx_push = 1; step(); step(); idle(); step();
    chk(raw_stat[4] == 0, "R7 at threshold", raw_stat[4], 0);
    rx_push = 1; step(); idle(); step();
    chk(raw_stat[4] == 1, "R7 above threshold", raw_stat[4], 1);
    // underflow (R4)
    for (int i = 0; i < 5; i++) begin rx_pop = 1; step(); end
    idle(); step();
    chk(raw_stat[2] == 1 && rx_level == 0, "R4 underflow", raw_stat, 4);
    // zero mask (R10)
    mask_we = 1; mask_wdata = 0; step(); idle(); step(); step();
    chk(irq == 0 && raw_stat != 0, "R10 zero mask", irq, 0);
    mask_we = 1; mask_wdata = 6'h3F; step(); idle(); step();
    chk(irq == 1, "R10 irq returns", irq, 1);
    // random traffic with phases
    for (int i = 0; i < 4000; i++) begin
      int ph = (i / 250) % 4;
      tx_push = ($urandom % 4) < (ph == 0 ? 3 : 1);
      tx_pop  = ($urandom % 4) < (ph == 1 ? 3 : 1);
      rx_push = ($urandom % 4) < (ph == 2 ? 3 : 1);
      rx_pop  = ($urandom % 4) < (ph == 3 ? 3 : 1);
      tx_thr_we = ($urandom % 40) == 0;
      rx_thr_we = ($urandom % 40) == 0;
      thr_wdata = RW'($urandom);
      mask_we = ($urandom % 30) == 0;
      mask_wdata = 6'($urandom);
      clr_txo = ($urandom % 20) == 0;
      clr_rxu = ($urandom % 20) == 0;
      clr_rxo = ($urandom % 20) == 0;
      step();
    end
    idle(); step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule